// File: doc/BRIEF.md
# Masked SIMD Lane Execution Unit

This block is the arithmetic core of an eight-lane vector integer pipeline. One operation (add, subtract, low half of a multiply, or a signed less-than compare) is broadcast to every lane in the same cycle. Each lane works on one 32-bit element of two source vectors. The unit returns a full destination vector and a per-element write-enable, one cycle after a start pulse.

Each destination element falls into one of three classes. An element is active when its index is below the vector length and it is not masked off. It is masked off when masking is in force and its bit in the mask vector is clear. It is tail when its index is at or beyond the vector length. Two policy bits decide what masked-off and tail elements receive: either the old destination value or all ones. The compare operation produces one mask bit per element, packed into the low bits of the destination vector, so the result can serve as a mask for later operations.

Top module: `simd_mask_exec`

## Requirements
- R1: For op_i codes 0 (add), 1 (subtract a-b) and 2 (multiply, low 32 bits of the product), each active element i of result_o equals the operation applied to bits [32*i+31:32*i] of src_a_i and src_b_i, with results wrapping modulo 2^32.
- R2: For op_i code 3 (compare), bit i of result_o for an active element i is 1 when element i of src_a_i is less than element i of src_b_i as signed 32-bit values, and 0 otherwise. Bits 8 and above of result_o equal the same bits of old_i.
- R3: When vm_i is 1, every element below the vector length is active. When vm_i is 0, such an element is active only if bit i of v0_i is 1; otherwise it is masked off.
- R4: Element i is a tail element when i is greater than or equal to vl_i. A vl_i value above 8 acts as 8.
- R5: A masked-off element takes the value of old_i when vma_i is 0, and all ones when vma_i is 1. For compare, this applies to the element's single result bit.
- R6: A tail element takes the value of old_i when vta_i is 0, and all ones when vta_i is 1. For compare, this applies to the element's single result bit.
- R7: wr_en_o[i] is 1 exactly when element i was active in the operation that produced the current result.
- R8: valid_o is 1 in the cycle after a cycle with start_i high, and 0 otherwise. result_o and wr_en_o change only on a started cycle.
- R9: While rst_ni is low, valid_o, result_o and wr_en_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one operation |
| op_i | input | 2 | 0 add, 1 sub, 2 mul low, 3 signed less-than compare |
| vl_i | input | 4 | Active vector length, in elements |
| vm_i | input | 1 | 1 unmasked, 0 masked by v0_i |
| vta_i | input | 1 | Tail policy: 1 all ones, 0 keep old |
| vma_i | input | 1 | Masked-off policy: 1 all ones, 0 keep old |
| src_a_i | input | 256 | First source vector |
| src_b_i | input | 256 | Second source vector |
| old_i | input | 256 | Previous destination vector |
| v0_i | input | 256 | Mask vector; bit i governs element i |
| valid_o | output | 1 | Result valid |
| result_o | output | 256 | Destination vector |
| wr_en_o | output | 8 | Per-element write-enable |

## Verification
The hardest case to reach is an element where several rules interact. Examples are a masked-off element that is also past the vector length, where the tail rule must win, and a compare whose single mask bit must follow the same policy as a full 32-bit element. The sweep covers every vector length from 0 to 10 plus 15, every operation, both masking modes, all four policy combinations and three mask patterns. This puts every lane into each class under each policy. One lane pair is forced equal so that the compare also meets the equal-operands boundary.

// File: rtl/simd_exec_pkg.sv
package simd_exec_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_MUL   = 2'd2,
    OP_CMPLT = 2'd3
  } simd_op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_exec_pkg::*;
#(
  parameter int EW = 32
) (
  input  simd_op_e          op_i,
  input  logic [EW-1:0]     a_i,
  input  logic [EW-1:0]     b_i,
  output logic [EW-1:0]     res_o,
  output logic              lt_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      default: res_o = '0;
    endcase
  end

  assign lt_o = $signed(a_i) < $signed(b_i);
endmodule

// File: rtl/simd_elem_class.sv
module simd_elem_class #(
  parameter int LANES = 8,
  parameter int VLW   = $clog2(LANES + 1)
) (
  input  logic [VLW-1:0]   vl_i,
  input  logic             vm_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] active_o,
  output logic [LANES-1:0] masked_o,
  output logic [LANES-1:0] tail_o
);
  localparam logic [VLW-1:0] MaxVl = VLW'(LANES);

  logic [VLW-1:0] eff_vl;
  assign eff_vl = (vl_i > MaxVl) ? MaxVl : vl_i;

  for (genvar i = 0; i < LANES; i++) begin : g_cls
    assign tail_o[i]   = VLW'(i) >= eff_vl;
    assign masked_o[i] = !tail_o[i] && !vm_i && !mask_i[i];
    assign active_o[i] = !tail_o[i] && !masked_o[i];
  end
endmodule

// File: rtl/simd_merge.sv
module simd_merge #(
  parameter int W = 32
) (
  input  logic         active_i,
  input  logic         masked_i,
  input  logic         vta_i,
  input  logic         vma_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] old_i,
  output logic [W-1:0] out_o
);
  always_comb begin
    if (active_i)      out_o = val_i;
    else if (masked_i) out_o = vma_i ? '1 : old_i;
    else               out_o = vta_i ? '1 : old_i;
  end
endmodule

// File: rtl/simd_mask_exec.sv
module simd_mask_exec
  import simd_exec_pkg::*;
#(
  parameter int LANES = 8,
  parameter int EW    = 32,
  localparam int VW   = LANES * EW,
  localparam int VLW  = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic             vm_i,
  input  logic             vta_i,
  input  logic             vma_i,
  input  logic [VW-1:0]    src_a_i,
  input  logic [VW-1:0]    src_b_i,
  input  logic [VW-1:0]    old_i,
  input  logic [VW-1:0]    v0_i,
  output logic             valid_o,
  output logic [VW-1:0]    result_o,
  output logic [LANES-1:0] wr_en_o
);
  simd_op_e op;
  assign op = simd_op_e'(op_i);

  logic [LANES-1:0] active, masked, tail, lt_bits, cmp_bits;
  logic [VW-1:0]    arith_vec, next_res;

  simd_elem_class #(.LANES(LANES), .VLW(VLW)) u_cls (
    .vl_i(vl_i), .vm_i(vm_i), .mask_i(v0_i[LANES-1:0]),
    .active_o(active), .masked_o(masked), .tail_o(tail)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EW-1:0] raw;
    simd_lane #(.EW(EW)) u_lane (
      .op_i(op), .a_i(src_a_i[i*EW +: EW]), .b_i(src_b_i[i*EW +: EW]),
      .res_o(raw), .lt_o(lt_bits[i])
    );
    simd_merge #(.W(EW)) u_mrg (
      .active_i(active[i]), .masked_i(masked[i]), .vta_i(vta_i), .vma_i(vma_i),
      .val_i(raw), .old_i(old_i[i*EW +: EW]), .out_o(arith_vec[i*EW +: EW])
    );
    // compare writes one bit per element into the low bits
    simd_merge #(.W(1)) u_mrg_bit (
      .active_i(active[i]), .masked_i(masked[i]), .vta_i(vta_i), .vma_i(vma_i),
      .val_i(lt_bits[i]), .old_i(old_i[i]), .out_o(cmp_bits[i])
    );
  end

  always_comb begin
    if (op == OP_CMPLT) next_res = {old_i[VW-1:LANES], cmp_bits};
    else                next_res = arith_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wr_en_o  <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        result_o <= next_res;
        wr_en_o  <= active;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  a_r8_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!valid_o && $stable(result_o) && $stable(wr_en_o)));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    a_r6_tail_no_wren: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && vl_i <= VLW'(i)) |=> !wr_en_o[i]);
    a_r3_masked_no_wren: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !vm_i && !v0_i[i]) |=> !wr_en_o[i]);
    a_r6_tail_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && op_i != 2'd3 && vl_i <= VLW'(i) && !vta_i)
      |=> result_o[i*EW +: EW] == $past(old_i[i*EW +: EW]));
    a_r6_tail_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && op_i != 2'd3 && vl_i <= VLW'(i) && vta_i)
      |=> &result_o[i*EW +: EW]);
    a_r5_masked_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && op_i != 2'd3 && vl_i > VLW'(i) && !vm_i && !v0_i[i] && !vma_i)
      |=> result_o[i*EW +: EW] == $past(old_i[i*EW +: EW]));
  end

  a_r2_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'd3) |=> result_o[VW-1:LANES] == $past(old_i[VW-1:LANES]));
endmodule

// File: tb/sim_simd_mask_exec.sv
`timescale 1ns/1ps
module sim_simd_mask_exec;
  localparam int L = 8;
  localparam int E = 32;
  localparam int VW = L * E;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] op = 0;
  logic [3:0] vl = 0;
  logic vm = 0, vta = 0, vma = 0;
  logic [VW-1:0] a = 0, b = 0, old = 0, v0 = 0;
  logic valid;
  logic [VW-1:0] res;
  logic [L-1:0] wen;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  simd_mask_exec u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .vl_i(vl),
    .vm_i(vm), .vta_i(vta), .vma_i(vma), .src_a_i(a), .src_b_i(b),
    .old_i(old), .v0_i(v0), .valid_o(valid), .result_o(res), .wr_en_o(wen)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(output logic [VW-1:0] er, output logic [L-1:0] ew);
    int evl;
    logic t, m, ac, lt;
    logic [31:0] ea, eb, v;
    evl = (vl > 8) ? 8 : int'(vl);
    er = old;
    for (int i = 0; i < L; i++) begin
      t  = i >= evl;
      m  = !t && !vm && !v0[i];
      ac = !t && !m;
      ew[i] = ac;
      ea = a[i*E +: E];
      eb = b[i*E +: E];
      case (op)
        2'd0: v = ea + eb;
        2'd1: v = ea - eb;
        2'd2: v = ea * eb;
        default: v = '0;
      endcase
      lt = $signed(ea) < $signed(eb);
      if (op == 2'd3)
        er[i] = ac ? lt : m ? (vma ? 1'b1 : old[i]) : (vta ? 1'b1 : old[i]);
      else
        er[i*E +: E] = ac ? v : m ? (vma ? '1 : old[i*E +: E]) : (vta ? '1 : old[i*E +: E]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] er;
    logic [L-1:0] ew;
    logic [7:0] pats [3];
    pats[0] = 8'hB4; pats[1] = 8'h00; pats[2] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", VW'(valid), '0);
    chk("R9 result in reset", res, '0);
    chk("R9 wr_en in reset", VW'(wen), '0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 idle after reset", VW'(valid), '0);
    for (int vi = 0; vi < 12; vi++)
      for (int o = 0; o < 4; o++)
        for (int k = 0; k < 16; k++)
          for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < VW / 32; w++) begin
              seed = nxt(seed); a[w*32 +: 32] = seed;
              seed = nxt(seed); b[w*32 +: 32] = seed;
              seed = nxt(seed); old[w*32 +: 32] = seed;
              seed = nxt(seed); v0[w*32 +: 32] = seed;
            end
            b[2*E +: E] = a[2*E +: E];
            v0[L-1:0] = pats[p];
            vl = (vi < 11) ? 4'(vi) : 4'd15;
            op = 2'(o);
            vm = k[0]; vta = k[1]; vma = k[2];
            if (k[3]) continue;
            start = 1;
            run_one(er, ew);
            @(negedge clk);
            start = 0;
            chk("R8 valid after start", VW'(valid), VW'(1'b1));
            if (op == 2'd3) chk("R2 R3 R4 R5 R6 compare result", res, er);
            else            chk("R1 R3 R4 R5 R6 arith result", res, er);
            chk("R7 write enable", VW'(wen), VW'(ew));
            a = ~a; old = ~old;
            @(negedge clk);
            chk("R8 no valid without start", VW'(valid), '0);
            chk("R8 result held while idle", res, er);
          end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule